// File: doc/BRIEF.md
# AXI-to-HBM Beat Address Mapper

This block sits between an AXI address channel and the command path of a high-bandwidth DRAM stack. It takes one read or write request, made of a byte address and a burst length, and emits one DRAM column command for each 32-byte beat of an incrementing burst. Every command carries the stack select, the destination port and the DRAM coordinates of that beat: row, stack ID, bank group, bank and column.

Two mapping modes are supported. In the default mode the lowest bank-group bit sits at address bit 5, so consecutive beats of a burst alternate between two bank groups. In the plain mode the bank-group bits sit with the bank bits, above the column. Three device kinds are handled: a single-stack 16-bank part and two dual-stack 32-bank parts, one with a 34-bit address and one with a 35-bit address. The device kind and the mapping mode are static inputs that the block captures when it accepts a request.

Top module: `hbm_addr_mapper`

## Requirements
- R1: While reset is held and just after it is released, cmd_valid_o is 0 and req_ready_o is 1.
- R2: A request with req_len_i = L produces exactly L+1 commands. cmd_last_o is 1 on the final command only, and cmd_write_o equals the req_write_i of the request. cmd_valid_o stays high from acceptance until the final command is taken and is 0 in the cycle after that.
- R3: The command for beat k decodes the byte address (A with bits [4:0] cleared) + 32*k, modulo 2^35. A carry may propagate into the port and stack bits.
- R4: With dev_sel_i = 2 (35-bit addressing), stack = addr[34] and port = addr[33:30]. With any other dev_sel_i value (34-bit addressing), stack = addr[33] and port = addr[32:29].
- R5: With dev_sel_i = 0 or 3 (16-bank part) and map_mode_i = 0, the mapping is bg[0]=addr[5], col=addr[10:6], bg[1]=addr[11], ba=addr[13:12], row=addr[28:14], and sid=0.
- R6: With dev_sel_i = 1 (8 Gb dual stack) or 2 (16 Gb dual stack), sid=addr[14] and ba=addr[13:12]. The row is addr[28:15] zero-extended to 15 bits for dev_sel_i = 1, and addr[29:15] for dev_sel_i = 2.
- R7: With map_mode_i = 1 the mapping is col=addr[9:5], bg=addr[11:10], and the bank, stack-ID and row fields are the same as in mode 0.
- R8: In mode 0 on the 16-bank part, address 0 with req_len_i = 1 gives two commands. The first has all fields 0. The second differs only in bg = 1.
- R9: req_ready_o is 0 from the cycle after acceptance until the final command has been taken. No new request is accepted in that window.
- R10: While cmd_valid_o is 1 and cmd_ready_i is 0, every command output holds its value into the next cycle.
- R11: Changes on dev_sel_i and map_mode_i during a burst have no effect on its commands. The values present at acceptance apply to every beat.
- R12: Address bits [4:0] have no effect on any command field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_sel_i | input | 2 | Device kind: 0 single stack, 1 dual stack 8 Gb, 2 dual stack 16 Gb, 3 as 0 |
| map_mode_i | input | 1 | 0 interleaved bank groups, 1 plain row-bank-column |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (block idle) |
| req_addr_i | input | 35 | Byte address of the first beat |
| req_len_i | input | 8 | Beats minus one |
| req_write_i | input | 1 | 1 for write, 0 for read |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command ready |
| cmd_stack_o | output | 1 | Stack select |
| cmd_port_o | output | 4 | Destination port |
| cmd_row_o | output | 15 | Row |
| cmd_sid_o | output | 1 | Stack ID |
| cmd_bg_o | output | 2 | Bank group |
| cmd_ba_o | output | 2 | Bank |
| cmd_col_o | output | 5 | Column (column address bits 5:1) |
| cmd_write_o | output | 1 | Write flag of the burst |
| cmd_last_o | output | 1 | Final beat of the burst |

## Verification
The assertions check, on every cycle, the handshake behaviour: commands hold steady under back-pressure, cmd_valid_o falls after the last command is taken, and a burst starts only from an accepted request. They also check that interleaved bursts flip bg[0] on every beat and that the zero-filled fields stay zero for the smaller parts. Only the bench's scenarios can show the bit positions of each field for every device and mode. The same holds for the beat count, the carry of the beat address into the upper bits, the effect of the low address bits, and the immunity of a running burst to configuration changes.

// File: rtl/hbm_map_pkg.sv
package hbm_map_pkg;
  typedef enum logic [1:0] {
    DEV_4H     = 2'd0,
    DEV_8H_8G  = 2'd1,
    DEV_8H_16G = 2'd2,
    DEV_RSVD   = 2'd3
  } dev_e;

  typedef enum logic {
    MAP_RBC_BGI = 1'b0,
    MAP_RBC     = 1'b1
  } map_e;

  localparam int unsigned ADDR_W   = 35;
  localparam int unsigned BEAT_LSB = 5;
  localparam int unsigned LEN_W    = 8;
  localparam int unsigned PORT_W   = 4;
  localparam int unsigned ROW_W    = 15;
  localparam int unsigned COL_W    = 5;
  localparam int unsigned BG_W     = 2;
  localparam int unsigned BA_W     = 2;
endpackage

// File: rtl/hbm_burst_seq.sv
module hbm_burst_seq
  import hbm_map_pkg::*;
#(
  parameter int unsigned ADDR_W   = hbm_map_pkg::ADDR_W,
  parameter int unsigned BEAT_LSB = hbm_map_pkg::BEAT_LSB,
  parameter int unsigned LEN_W    = hbm_map_pkg::LEN_W,
  localparam int unsigned BW      = ADDR_W - BEAT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_write_i,
  input  dev_e              dev_i,
  input  map_e              mode_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [BW-1:0]     beat_o,
  output logic              last_o,
  output logic              write_o,
  output dev_e              dev_o,
  output map_e              mode_o
);
  localparam logic [BW-1:0]    BEAT_ONE = BW'(1);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

  logic             busy_q, wr_q;
  logic [BW-1:0]    beat_q;
  logic [LEN_W-1:0] left_q;
  dev_e             dev_q;
  map_e             mode_q;
  logic             accept, take, fin;
  logic             unused_lsb;

  assign unused_lsb = ^req_addr_i[BEAT_LSB-1:0];
  assign accept     = req_valid_i & ~busy_q;
  assign take       = busy_q & cmd_ready_i;
  assign fin        = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      beat_q <= '0;
      left_q <= '0;
      dev_q  <= DEV_4H;
      mode_q <= MAP_RBC_BGI;
    end else if (accept) begin
      // configuration is captured only here
      busy_q <= 1'b1;
      wr_q   <= req_write_i;
      beat_q <= req_addr_i[ADDR_W-1:BEAT_LSB];
      left_q <= req_len_i;
      dev_q  <= dev_i;
      mode_q <= mode_i;
    end else if (take) begin
      if (fin) begin
        busy_q <= 1'b0;
      end else begin
        beat_q <= beat_q + BEAT_ONE;
        left_q <= left_q - LEN_ONE;
      end
    end
  end

  assign req_ready_o = ~busy_q;
  assign cmd_valid_o = busy_q;
  assign beat_o      = beat_q;
  assign last_o      = fin;
  assign write_o     = wr_q;
  assign dev_o       = dev_q;
  assign mode_o      = mode_q;

  // R10
  hold_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(beat_o) && $stable(last_o)
                                    && $stable(write_o));
  // R2
  drop_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && last_o |=> !cmd_valid_o);
  // R9
  start_from_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> $past(req_valid_i && req_ready_o));
  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && $past(cmd_valid_o) |-> $stable(dev_o) && $stable(mode_o));
endmodule

// File: rtl/hbm_field_decode.sv
module hbm_field_decode
  import hbm_map_pkg::*;
#(
  parameter int unsigned ADDR_W   = hbm_map_pkg::ADDR_W,
  parameter int unsigned BEAT_LSB = hbm_map_pkg::BEAT_LSB,
  parameter int unsigned PORT_W   = hbm_map_pkg::PORT_W,
  parameter int unsigned ROW_W    = hbm_map_pkg::ROW_W,
  parameter int unsigned COL_W    = hbm_map_pkg::COL_W,
  parameter int unsigned BG_W     = hbm_map_pkg::BG_W,
  parameter int unsigned BA_W     = hbm_map_pkg::BA_W,
  localparam int unsigned BW      = ADDR_W - BEAT_LSB
) (
  input  logic [BW-1:0]     beat_i,
  input  dev_e              dev_i,
  input  map_e              mode_i,
  output logic              stack_o,
  output logic [PORT_W-1:0] port_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              sid_o,
  output logic [BG_W-1:0]   bg_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [COL_W-1:0]  col_o
);
  localparam int unsigned UA_W      = BW - PORT_W - 1;
  localparam int unsigned BA_POS    = COL_W + BG_W;
  localparam int unsigned SID_POS   = BA_POS + BA_W;
  localparam int unsigned ROW_SID   = SID_POS + 1;
  localparam int unsigned ROW_NOSID = SID_POS;

  logic            wide, has_sid;
  logic [UA_W-1:0] ua;

  assign wide    = (dev_i == DEV_8H_16G);
  assign has_sid = (dev_i == DEV_8H_8G) || wide;

  // top user bit is a port bit on 34-bit devices
  for (genvar i = 0; i < UA_W; i++) begin : g_ua
    if (i == UA_W - 1) begin : g_top
      assign ua[i] = beat_i[i] & wide;
    end else begin : g_low
      assign ua[i] = beat_i[i];
    end
  end

  assign stack_o = wide ? beat_i[BW-1] : beat_i[BW-2];
  assign port_o  = wide ? beat_i[BW-2 -: PORT_W] : beat_i[BW-3 -: PORT_W];

  always_comb begin
    if (mode_i == MAP_RBC_BGI) begin
      col_o = ua[1 +: COL_W];
      bg_o  = {ua[COL_W+1 +: BG_W-1], ua[0]};
    end else begin
      col_o = ua[0 +: COL_W];
      bg_o  = ua[COL_W +: BG_W];
    end
    ba_o  = ua[BA_POS +: BA_W];
    sid_o = has_sid & ua[SID_POS];
    row_o = has_sid ? ua[ROW_SID +: ROW_W] : ua[ROW_NOSID +: ROW_W];
  end
endmodule

// File: rtl/hbm_addr_mapper.sv
module hbm_addr_mapper
  import hbm_map_pkg::*;
#(
  parameter int unsigned ADDR_W   = hbm_map_pkg::ADDR_W,
  parameter int unsigned BEAT_LSB = hbm_map_pkg::BEAT_LSB,
  parameter int unsigned LEN_W    = hbm_map_pkg::LEN_W,
  parameter int unsigned PORT_W   = hbm_map_pkg::PORT_W,
  parameter int unsigned ROW_W    = hbm_map_pkg::ROW_W,
  parameter int unsigned COL_W    = hbm_map_pkg::COL_W,
  parameter int unsigned BG_W     = hbm_map_pkg::BG_W,
  parameter int unsigned BA_W     = hbm_map_pkg::BA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        dev_sel_i,
  input  logic              map_mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_write_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_stack_o,
  output logic [PORT_W-1:0] cmd_port_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic              cmd_sid_o,
  output logic [BG_W-1:0]   cmd_bg_o,
  output logic [BA_W-1:0]   cmd_ba_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              cmd_write_o,
  output logic              cmd_last_o
);
  localparam int unsigned BW = ADDR_W - BEAT_LSB;

  logic [BW-1:0] beat;
  dev_e          dev_q;
  map_e          mode_q;

  hbm_burst_seq #(
    .ADDR_W(ADDR_W), .BEAT_LSB(BEAT_LSB), .LEN_W(LEN_W)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .req_write_i (req_write_i),
    .dev_i       (dev_e'(dev_sel_i)),
    .mode_i      (map_e'(map_mode_i)),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .beat_o      (beat),
    .last_o      (cmd_last_o),
    .write_o     (cmd_write_o),
    .dev_o       (dev_q),
    .mode_o      (mode_q)
  );

  hbm_field_decode #(
    .ADDR_W(ADDR_W), .BEAT_LSB(BEAT_LSB), .PORT_W(PORT_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .BG_W(BG_W), .BA_W(BA_W)
  ) i_dec (
    .beat_i  (beat),
    .dev_i   (dev_q),
    .mode_i  (mode_q),
    .stack_o (cmd_stack_o),
    .port_o  (cmd_port_o),
    .row_o   (cmd_row_o),
    .sid_o   (cmd_sid_o),
    .bg_o    (cmd_bg_o),
    .ba_o    (cmd_ba_o),
    .col_o   (cmd_col_o)
  );

  // R5
  bg_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && !cmd_last_o && mode_q == MAP_RBC_BGI
    |=> cmd_bg_o[0] != $past(cmd_bg_o[0]));
  // R5
  no_sid_single_stack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && (dev_q == DEV_4H || dev_q == DEV_RSVD) |-> !cmd_sid_o);
  // R6
  short_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && dev_q == DEV_8H_8G |-> !cmd_row_o[ROW_W-1]);
  // R10
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> $stable(cmd_row_o) && $stable(cmd_col_o)
      && $stable(cmd_bg_o) && $stable(cmd_ba_o) && $stable(cmd_port_o));
endmodule

// File: tb/test_hbm_addr_mapper.sv
`timescale 1ns/1ps
module test_hbm_addr_mapper;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  dev_sel_i = '0;
  logic        map_mode_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [34:0] req_addr_i = '0;
  logic [7:0]  req_len_i = '0;
  logic        req_write_i = 1'b0;
  logic        cmd_valid_o;
  logic        cmd_ready_i = 1'b0;
  logic        cmd_stack_o, cmd_sid_o, cmd_write_o, cmd_last_o;
  logic [3:0]  cmd_port_o;
  logic [14:0] cmd_row_o;
  logic [1:0]  cmd_bg_o, cmd_ba_o;
  logic [4:0]  cmd_col_o;

  always #10 clk = ~clk;

  hbm_addr_mapper i_hbm_addr_mapper (
    .clk_i(clk), .rst_ni(rst_ni), .dev_sel_i(dev_sel_i), .map_mode_i(map_mode_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .req_len_i(req_len_i), .req_write_i(req_write_i), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .cmd_stack_o(cmd_stack_o), .cmd_port_o(cmd_port_o),
    .cmd_row_o(cmd_row_o), .cmd_sid_o(cmd_sid_o), .cmd_bg_o(cmd_bg_o),
    .cmd_ba_o(cmd_ba_o), .cmd_col_o(cmd_col_o), .cmd_write_o(cmd_write_o),
    .cmd_last_o(cmd_last_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [29:0] cap [0:255];
  wire  [29:0] got = {cmd_stack_o, cmd_port_o, cmd_row_o, cmd_sid_o, cmd_bg_o, cmd_ba_o, cmd_col_o};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected field word {stack, port, row, sid, bg, ba, col}
  function automatic logic [29:0] model(input logic [34:0] a, input logic [1:0] dev, input logic mode);
    logic st, sd; logic [3:0] pt; logic [14:0] rw; logic [1:0] g, b; logic [4:0] c;
    st = (dev == 2) ? a[34] : a[33];
    pt = (dev == 2) ? a[33:30] : a[32:29];
    if (mode == 1'b0) begin g = {a[11], a[5]}; c = a[10:6]; end
    else              begin g = a[11:10];      c = a[9:5];  end
    b = a[13:12];
    case (dev)
      2'd1:    begin sd = a[14]; rw = {1'b0, a[28:15]}; end
      2'd2:    begin sd = a[14]; rw = a[29:15]; end
      default: begin sd = 1'b0;  rw = a[28:14]; end
    endcase
    return {st, pt, rw, sd, g, b, c};
  endfunction

  task automatic run_burst(input logic [34:0] addr, input logic [7:0] len, input bit wr,
                           input logic [1:0] dev, input logic mode);
    int k; bit fin; string tag; logic [29:0] exp;
    tag = (mode == 1'b1) ? "R7/R3/R4" : (dev == 2'd1 || dev == 2'd2) ? "R6/R3/R4" : "R5/R3/R4";
    @(negedge clk);
    dev_sel_i = dev; map_mode_i = mode; req_addr_i = addr; req_len_i = len;
    req_write_i = wr; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    req_addr_i  = {$urandom, $urandom} & 35'h7_ffff_ffff;
    k = 0; fin = 0;
    while (!fin) begin
      // R11: churn the configuration mid-burst
      dev_sel_i  = 2'($urandom);
      map_mode_i = 1'($urandom);
      chk(!req_ready_o, "R9 ready during burst", req_ready_o, 0);
      cmd_ready_i = ($urandom % 4) != 0;
      if (!cmd_valid_o) begin
        chk(0, "R2 valid dropped early", 0, 1);
        fin = 1;
      end else begin
        exp = model((addr & ~35'h1f) + 35'(k) * 35'd32, dev, mode);
        if (!cmd_ready_i) chk(got == exp, "R10/R11 stalled fields", got, exp);
        else begin
          chk(got == exp, {tag, "/R11/R12 fields"}, got, exp);
          chk(cmd_last_o == (k == int'(len)), "R2 last", cmd_last_o, k == int'(len));
          chk(cmd_write_o == wr, "R2 write flag", cmd_write_o, wr);
          cap[k] = got;
          if (k == int'(len)) fin = 1;
          k++;
        end
      end
      @(negedge clk);
    end
    cmd_ready_i = 1'b0;
    chk(!cmd_valid_o, "R2 valid after last", cmd_valid_o, 0);
    chk(req_ready_o, "R9 ready after last", req_ready_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o, "R1 valid in reset", cmd_valid_o, 0);
    chk(req_ready_o, "R1 ready in reset", req_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!cmd_valid_o, "R1 valid after reset", cmd_valid_o, 0);
    chk(req_ready_o, "R1 ready after reset", req_ready_o, 1);

    // R8 default two-beat example
    run_burst(35'h0, 8'd1, 1'b0, 2'd0, 1'b0);
    chk(cap[0] == 30'h0, "R8 first beat", cap[0], 30'h0);
    chk(cap[1] == 30'h80, "R8 second beat", cap[1], 30'h80);

    // R12 low bits ignored
    run_burst(35'h1f, 8'd0, 1'b1, 2'd0, 1'b0);
    chk(cap[0] == 30'h0, "R12 low bits", cap[0], 30'h0);

    // R4 stack/port per width
    run_burst({1'b1, 4'ha, 30'h0}, 8'd0, 1'b0, 2'd2, 1'b0);
    chk(cap[0] == {1'b1, 4'ha, 25'h0}, "R4 wide", cap[0], {1'b1, 4'ha, 25'h0});
    run_burst({1'b1, 4'ha, 30'h0}, 8'd0, 1'b0, 2'd0, 1'b0);
    chk(cap[0] == {1'b1, 4'h4, 25'h0}, "R4 narrow", cap[0], {1'b1, 4'h4, 25'h0});

    // R6 stack ID versus row bit
    run_burst(35'h4000, 8'd0, 1'b0, 2'd1, 1'b0);
    chk(cap[0] == 30'h200, "R6 sid", cap[0], 30'h200);
    run_burst(35'h4000, 8'd0, 1'b0, 2'd0, 1'b0);
    chk(cap[0] == 30'h400, "R5 row lsb", cap[0], 30'h400);

    // R7 bit 10 is bank group in plain mode, column in interleaved mode
    run_burst(35'h400, 8'd0, 1'b0, 2'd0, 1'b1);
    chk(cap[0] == 30'h80, "R7 plain bg", cap[0], 30'h80);
    run_burst(35'h400, 8'd0, 1'b0, 2'd0, 1'b0);
    chk(cap[0] == 30'h10, "R5 interleaved col", cap[0], 30'h10);

    // R3 carry into port bits, long burst
    run_burst(35'h1fff_ffe0, 8'd255, 1'b1, 2'd1, 1'b0);

    for (int n = 0; n < 150; n++) begin
      logic [7:0] len;
      len = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 6);
      run_burst({$urandom, $urandom} & 35'h7_ffff_ffff, len, 1'($urandom),
                2'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule